// File: doc/BRIEF.md
# DS3 Loss-of-Signal Detector

This block watches the two rails of a DS3 receive bit stream, one bit per enabled receive clock, and declares loss of signal. A bit period is a mark when either rail carries a pulse, and a space when both rails are low. A long unbroken run of spaces raises the loss flag. Once it is raised, the flag drops only when the mark density over a sliding window of recent bits reaches a minimum. The two different rules give hysteresis, so a line that is only marginal does not make the flag toggle.

A separate loss indicator from the line interface can also force the declaration. That indicator is copied into bit 0 of a status word, so software can see it apart from the detector's own verdict. The bit rate is set by a clock enable on a faster fabric clock, and reset is synchronous.

Top module: `ds3_los_detect`

## Requirements
- R1: A bit counts as a mark when `pos_i` or `neg_i` is high, or both are. It counts as a space only when both rails are low.
- R2: After the 180th consecutive enabled space is sampled at a clock edge, `los_o` is high from that same edge onward. It is 0 when only 179 spaces have been seen.
- R3: Any enabled mark resets the space run to zero. 179 spaces, then a mark, then 179 more spaces leave `los_o` low.
- R4: A declared loss clears only on an enabled bit for which two conditions both hold: at least 180 enabled bits have been sampled since the declaration, and at least 60 of the last 180 enabled bits are marks. `los_o` falls at the edge that samples that bit.
- R5: With only 59 marks in the last 180 bits, a declared loss stays set.
- R6: While `ext_los_i` is high, `los_o` is high from the next clock edge on. On an enabled cycle it also sets the internal flag and holds it, and no density test can clear the flag until `ext_los_i` is low.
- R7: `status_o[0]` equals the value `ext_los_i` had at the previous edge. All other bits of `status_o` are 0.
- R8: A cycle with `en` low consumes no bit. It changes neither the space run, nor the window, nor the flag.
- R9: While `rst` is high, the counters, the window history and the flag are cleared. After reset, `los_o` and `status_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Bit-period enable; one bit is consumed when high |
| pos_i | input | 1 | Positive-rail pulse for this bit |
| neg_i | input | 1 | Negative-rail pulse for this bit |
| ext_los_i | input | 1 | Active-high loss indicator from the line interface |
| los_o | output | 1 | Combined loss-of-signal flag, registered |
| status_o | output | STAT_W | Status word; bit 0 mirrors `ext_los_i` |

## Verification
Some rules hold on every cycle, and the assertions check them there:
- a mark from either rail empties the space run;
- a disabled cycle freezes the counters and the flag;
- the counters stay within their limits;
- the external indicator forces `los_o` and shows in status;
- no clear happens before a full window has elapsed or while the mark count is too low.

Other behaviour depends on a history of bits, and only the bench's scenarios show it:
- the exact edge at which the 180th space raises the flag;
- the 59/60 mark boundary in a window made only of post-declaration bits;
- agreement with an independent window model under random densities.

// File: rtl/ds3_los_pkg.sv
package ds3_los_pkg;

  typedef enum logic {
    ST_SIGNAL = 1'b0,
    ST_LOST   = 1'b1
  } los_state_e;

  function automatic int cnt_width(input int max_val);
    return (max_val < 1) ? 1 : $clog2(max_val + 1);
  endfunction

endpackage

// File: rtl/los_zero_run.sv
module los_zero_run #(
  parameter int RUN_LEN = 180
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic mark_i,
  output logic hit_o
);
  localparam int CW = ds3_los_pkg::cnt_width(RUN_LEN);
  localparam logic [CW-1:0] LIMIT = CW'(RUN_LEN);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_next;

  always_comb begin
    if (mark_i)              cnt_next = '0;
    else if (cnt_q == LIMIT) cnt_next = cnt_q;
    else                     cnt_next = cnt_q + 1'b1;
  end

  assign hit_o = (cnt_next == LIMIT);

  always_ff @(posedge clk) begin
    if (rst)     cnt_q <= '0;
    else if (en) cnt_q <= cnt_next;
  end
endmodule

// File: rtl/los_ones_window.sv
module los_ones_window #(
  parameter int WIN_LEN = 180
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic mark_i,
  output logic [ds3_los_pkg::cnt_width(WIN_LEN)-1:0] ones_next_o
);
  localparam int CW = ds3_los_pkg::cnt_width(WIN_LEN);

  logic [WIN_LEN-1:0] hist_q;
  logic [CW-1:0]      ones_q;
  logic               leaving;

  assign leaving     = hist_q[WIN_LEN-1];
  assign ones_next_o = ones_q + CW'(mark_i) - CW'(leaving);

  always_ff @(posedge clk) begin
    if (rst) begin
      hist_q <= '0;
      ones_q <= '0;
    end else if (en) begin
      hist_q <= {hist_q[WIN_LEN-2:0], mark_i};
      ones_q <= ones_next_o;
    end
  end
endmodule

// File: rtl/los_state.sv
module los_state #(
  parameter int WIN_LEN  = 180,
  parameter int ONES_MIN = 60
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic run_hit_i,
  input  logic [ds3_los_pkg::cnt_width(WIN_LEN)-1:0] ones_next_i,
  input  logic ext_i,
  output logic flag_o,
  output logic los_o
);
  import ds3_los_pkg::*;
  localparam int CW = cnt_width(WIN_LEN);
  localparam logic [CW-1:0] WIN_FULL = CW'(WIN_LEN);
  localparam logic [CW-1:0] MIN_ONES = CW'(ONES_MIN);

  los_state_e    st_q, st_next;
  logic [CW-1:0] seen_q, seen_inc, seen_next;
  logic          los_q;

  assign seen_inc = (seen_q == WIN_FULL) ? seen_q : seen_q + 1'b1;

  always_comb begin
    st_next   = st_q;
    seen_next = seen_q;
    if (en) begin
      if (st_q == ST_SIGNAL) begin
        if (run_hit_i || ext_i) begin
          st_next   = ST_LOST;
          seen_next = '0;
        end
      end else begin
        seen_next = seen_inc;
        if (!ext_i && seen_inc == WIN_FULL && ones_next_i >= MIN_ONES)
          st_next = ST_SIGNAL;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_SIGNAL;
      seen_q <= '0;
      los_q  <= 1'b0;
    end else begin
      st_q   <= st_next;
      seen_q <= seen_next;
      los_q  <= (st_next == ST_LOST) || ext_i;
    end
  end

  assign flag_o = (st_q == ST_LOST);
  assign los_o  = los_q;
endmodule

// File: rtl/ds3_los_detect.sv
module ds3_los_detect #(
  parameter int ZERO_RUN = 180,
  parameter int WIN_LEN  = 180,
  parameter int ONES_MIN = 60,
  parameter int STAT_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              pos_i,
  input  logic              neg_i,
  input  logic              ext_los_i,
  output logic              los_o,
  output logic [STAT_W-1:0] status_o
);
  localparam int CW = ds3_los_pkg::cnt_width(WIN_LEN);

  logic          mark;
  logic          run_hit;
  logic [CW-1:0] ones_next;
  logic          flag;
  logic [STAT_W-1:0] status_q;

  assign mark = pos_i | neg_i;

  los_zero_run #(.RUN_LEN(ZERO_RUN)) u_zr (
    .clk(clk), .rst(rst), .en(en), .mark_i(mark), .hit_o(run_hit)
  );

  los_ones_window #(.WIN_LEN(WIN_LEN)) u_win (
    .clk(clk), .rst(rst), .en(en), .mark_i(mark), .ones_next_o(ones_next)
  );

  los_state #(.WIN_LEN(WIN_LEN), .ONES_MIN(ONES_MIN)) u_st (
    .clk(clk), .rst(rst), .en(en), .run_hit_i(run_hit),
    .ones_next_i(ones_next), .ext_i(ext_los_i), .flag_o(flag), .los_o(los_o)
  );

  always_ff @(posedge clk) begin
    if (rst) status_q <= '0;
    else     status_q <= {{(STAT_W-1){1'b0}}, ext_los_i};
  end

  assign status_o = status_q;
endmodule

// File: rtl/ds3_los_chk.sv
module ds3_los_chk #(
  parameter int ZERO_RUN = 180,
  parameter int WIN_LEN  = 180,
  parameter int ONES_MIN = 60,
  parameter int STAT_W   = 8,
  parameter int CW       = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              en,
  input logic              pos_i,
  input logic              neg_i,
  input logic              ext_los_i,
  input logic              los_o,
  input logic [STAT_W-1:0] status_o,
  input logic [CW-1:0]     run_cnt,
  input logic [CW-1:0]     ones_cnt,
  input logic [CW-1:0]     seen_cnt,
  input logic              flag
);
  // R1: a pulse on one rail alone is a mark
  a_r1_single_rail_mark: assert property (@(posedge clk) disable iff (rst)
    en && (pos_i ^ neg_i) |=> run_cnt == '0);

  // R2: the last space of a full run declares loss
  a_r2_run_declares: assert property (@(posedge clk) disable iff (rst)
    en && !flag && !pos_i && !neg_i && run_cnt == CW'(ZERO_RUN - 1) |=> flag && los_o);

  // R3: a mark empties the space run
  a_r3_mark_resets_run: assert property (@(posedge clk) disable iff (rst)
    en && (pos_i || neg_i) |=> run_cnt == '0);

  a_r3_run_bounded: assert property (@(posedge clk) disable iff (rst)
    run_cnt <= CW'(ZERO_RUN) && ones_cnt <= CW'(WIN_LEN));

  // R4: no clear before a whole window has passed since the declaration
  a_r4_no_early_clear: assert property (@(posedge clk) disable iff (rst)
    flag && seen_cnt < CW'(WIN_LEN - 1) |=> flag);

  // R5: too few marks keeps the flag
  a_r5_low_density_holds: assert property (@(posedge clk) disable iff (rst)
    flag && ones_cnt < CW'(ONES_MIN - 1) |=> flag);

  // R6: the external indicator forces the output and holds the flag
  a_r6_ext_forces: assert property (@(posedge clk) disable iff (rst)
    ext_los_i |=> los_o);

  a_r6_ext_holds_flag: assert property (@(posedge clk) disable iff (rst)
    flag && ext_los_i |=> flag);

  // R7: status mirrors the indicator one edge late
  a_r7_status_mirror: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> status_o == {{(STAT_W-1){1'b0}}, $past(ext_los_i)});

  // R8: a disabled cycle changes nothing
  a_r8_idle_freezes: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(run_cnt) && $stable(ones_cnt) && $stable(flag));

  // R9: reset leaves everything cleared
  a_r9_reset_clears: assert property (@(posedge clk)
    $past(rst) |-> run_cnt == '0 && ones_cnt == '0 && !flag && !los_o && status_o == '0);
endmodule

bind ds3_los_detect ds3_los_chk #(
  .ZERO_RUN(ZERO_RUN), .WIN_LEN(WIN_LEN), .ONES_MIN(ONES_MIN),
  .STAT_W(STAT_W), .CW(ds3_los_pkg::cnt_width(WIN_LEN))
) u_chk (
  .clk(clk), .rst(rst), .en(en), .pos_i(pos_i), .neg_i(neg_i),
  .ext_los_i(ext_los_i), .los_o(los_o), .status_o(status_o),
  .run_cnt(CW'(u_zr.cnt_q)), .ones_cnt(u_win.ones_q),
  .seen_cnt(u_st.seen_q), .flag(flag)
);

// File: tb/ds3_los_detect_tb.sv
module ds3_los_detect_tb;
  localparam int RUN = 180;
  localparam int WIN = 180;
  localparam int MINO = 60;
  localparam int SW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0, pos = 1'b0, neg = 1'b0, ext = 1'b0;
  logic los;
  logic [SW-1:0] status;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // independent reference state
  int  m_run, m_ones, m_seen;
  bit  m_flag, m_los, m_ext;
  bit  m_hist[WIN];

  always #2.5 clk = ~clk;

  ds3_los_detect #(.ZERO_RUN(RUN), .WIN_LEN(WIN), .ONES_MIN(MINO), .STAT_W(SW)) u_dut (
    .clk(clk), .rst(rst), .en(en), .pos_i(pos), .neg_i(neg),
    .ext_los_i(ext), .los_o(los), .status_o(status)
  );

  function automatic void model_reset();
    m_run = 0; m_ones = 0; m_seen = 0; m_flag = 0; m_los = 0; m_ext = 0;
    for (int i = 0; i < WIN; i++) m_hist[i] = 0;
  endfunction

  function automatic void model_step(bit p, bit n, bit e, bit x);
    bit b = p | n;
    if (e) begin
      m_run = b ? 0 : ((m_run < RUN) ? m_run + 1 : RUN);
      m_ones = m_ones + int'(b) - int'(m_hist[WIN-1]);
      for (int i = WIN - 1; i > 0; i--) m_hist[i] = m_hist[i-1];
      m_hist[0] = b;
      if (!m_flag) begin
        if (m_run == RUN || x) begin m_flag = 1; m_seen = 0; end
      end else begin
        m_seen = (m_seen < WIN) ? m_seen + 1 : WIN;
        if (!x && m_seen >= WIN && m_ones >= MINO) m_flag = 0;
      end
    end
    m_los = m_flag | x;
    m_ext = x;
  endfunction

  task automatic check(string req, logic [SW-1:0] got, logic [SW-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, got, exp, $time);
    end
  endtask

  task automatic step(bit p, bit n, bit e, bit x, string req);
    @(negedge clk);
    pos = p; neg = n; en = e; ext = x;
    @(posedge clk);
    model_step(p, n, e, x);
    #1;
    check(req, SW'(los), SW'(m_los));
    check("R7", status, {{(SW-1){1'b0}}, m_ext});
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; en = 0; pos = 0; neg = 0; ext = 0;
    repeat (3) @(posedge clk);
    #1;
    model_reset();
    check("R9", SW'(los), '0);
    check("R9", status, '0);
    @(negedge clk);
    rst = 0;
  endtask

  task automatic spaces(int k, string req);
    for (int i = 0; i < k; i++) step(0, 0, 1, 0, req);
  endtask

  task automatic marks(int k, string req);
    for (int i = 0; i < k; i++) step(1, 0, 1, 0, req);
  endtask

  initial begin
    #900000;
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    model_reset();
    do_reset();

    // R2: 179 spaces leave flag low, 180th raises it
    spaces(179, "R2");
    check("R2", SW'(los), '0);
    spaces(1, "R2");
    check("R2", SW'(los), 1);

    // R4: all marks after declaration: clear exactly at bit 180
    marks(179, "R4");
    check("R4", SW'(los), 1);
    marks(1, "R4");
    check("R4", SW'(los), 0);

    // R3: a mark at position 180 restarts the run
    do_reset();
    spaces(179, "R3");
    step(0, 1, 1, 0, "R3");
    spaces(179, "R3");
    check("R3", SW'(los), 0);

    // R1: pulses on both rails together are a mark
    step(1, 1, 1, 0, "R1");
    spaces(179, "R1");
    check("R1", SW'(los), 0);
    spaces(1, "R1");
    check("R1", SW'(los), 1);

    // R5: 121 spaces + 59 marks keeps the flag; one more mark clears
    spaces(121, "R5");
    marks(59, "R5");
    check("R5", SW'(los), 1);
    marks(1, "R4");
    check("R4", SW'(los), 0);

    // R8: disabled cycles consume nothing
    do_reset();
    spaces(170, "R8");
    for (int i = 0; i < 50; i++) step(0, 0, 0, 0, "R8");
    check("R8", SW'(los), 0);
    spaces(10, "R8");
    check("R8", SW'(los), 1);

    // R6: external indicator forces and holds
    do_reset();
    step(1, 0, 0, 1, "R6");
    check("R6", SW'(los), 1);
    check("R7", status, 8'h01);
    for (int i = 0; i < 200; i++) step(1, 0, 1, 1, "R6");
    check("R6", SW'(los), 1);
    step(1, 0, 1, 0, "R6");
    check("R6", SW'(los), 0);

    // random segments of varying density
    do_reset();
    for (int s = 0; s < 120; s++) begin
      int dens = $urandom_range(0, 3);
      int len  = $urandom_range(50, 400);
      for (int i = 0; i < len; i++) begin
        bit b, e, x;
        case (dens)
          0: b = ($urandom_range(0, 499) == 0);
          1: b = ($urandom_range(0, 3) == 0);
          2: b = ($urandom_range(0, 2) == 0);
          default: b = $urandom_range(0, 1) == 1;
        endcase
        e = ($urandom_range(0, 9) != 0);
        x = ($urandom_range(0, 999) < 3);
        if ($urandom_range(0, 1) == 1) step(b, 0, e, x, "R4");
        else                           step(0, b, e, x, "R5");
      end
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule